// File: doc/BRIEF.md
# FP condition predicate branch unit

This unit judges a six-bit floating-point condition predicate against a four-bit condition-code nibble and acts on the verdict in one of four ways. It can pick the next program counter for a conditional branch. It can run a loop step that decrements a 16-bit counter. It can produce a set-byte value. It can raise a conditional trap. The condition nibble arrives already computed, and the unit performs no fetch and no memory write. The caller places the operands on the inputs, pulses `start`, and reads every result one cycle later while `done` is high.

The predicates follow IEEE comparison rules. When the NaN flag is set, an ordered comparison is false and its unordered counterpart is true. The program-counter input gives the address of the first extension word that follows the instruction words already consumed. Every fall-through address is that value plus the length of the extension words the operation skips.

Top module: `fpcc_branch_unit`

## Requirements
- R1: While reset is asserted, and until the first `start` after it, `done`, `pc_next`, `cnt_out`, `set_byte`, `trap_req`, `trap_vec` and `invalid` are all zero.
- R2: `done` goes high in the cycle after `start` is sampled high and is low otherwise. All other outputs change only on the edge where `start` is sampled high.
- R3: `cc_nib` bit 0 is NaN (N), bit 1 infinity, bit 2 zero (Z) and bit 3 negative (M). On `pred[3:0]`, the truth T is: 0 false; 1 Z; 2 !M&!Z&!N; 3 Z|(!M&!N); 4 M&!N&!Z; 5 (M&!N)|Z; 6 !N&!Z; 7 !N; 8 N; 9 N|Z; 10 N|(!M&!Z); 11 N|Z|!M; 12 N|(M&!Z); 13 M|Z|N; 14 !Z; 15 true.
- R4: `pred[4]` (signaling variant) and the infinity bit do not affect T. A predicate p and p+16 give identical results.
- R5: With `op_sel`=0 (branch), the displacement is `disp` when `disp_long`=1, or else `disp[15:0]` sign-extended. When T holds, `pc_next` = `pc_in` + displacement. Otherwise `pc_next` = `pc_in` + 4 when `disp_long`=1 and `pc_in` + 2 otherwise.
- R6: With `op_sel`=1 (decrement-and-branch), when T holds, `cnt_out` = `cnt_in` and `pc_next` = `pc_in` + 2.
- R7: With `op_sel`=1, when T is false, `cnt_out` = `cnt_in` − 1 modulo 2^16. If that new value is 0xFFFF, `pc_next` = `pc_in` + 2. Otherwise `pc_next` = `pc_in` + sign-extended `disp[15:0]`.
- R8: With `op_sel`=2 (set byte), `set_byte` is 0xFF when T holds and 0x00 otherwise, and `pc_next` = `pc_in`. For every other operation `set_byte` is 0x00.
- R9: With `op_sel`=3 (trap), `trap_ext` 2 skips 2 bytes, 3 skips 4 bytes and 4 skips none, so `pc_next` = `pc_in` + skip. When T holds, `trap_req`=1 and `trap_vec`=7. Otherwise both are 0.
- R10: The request is invalid when `pred[5]`=1, or when `op_sel`=3 with `trap_ext` other than 2, 3 or 4. An invalid request gives `invalid`=1, `pc_next`=`pc_in`, `cnt_out`=`cnt_in`, `set_byte`=0 and `trap_req`=0. Valid requests give `invalid`=0.
- R11: For branch, set-byte and trap operations `cnt_out` equals `cnt_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request strobe; inputs are sampled on this edge |
| op_sel | input | 2 | 0 branch, 1 decrement-and-branch, 2 set byte, 3 trap |
| pred | input | 6 | Condition predicate |
| cc_nib | input | 4 | Condition codes: N bit 0, infinity bit 1, Z bit 2, M bit 3 |
| pc_in | input | 32 | Address of the first extension word |
| disp | input | 32 | Branch displacement; only bits 15:0 used when short |
| disp_long | input | 1 | Branch uses a 32-bit displacement |
| cnt_in | input | 16 | Low word of the loop counter register |
| trap_ext | input | 3 | Trap operand-size code |
| done | output | 1 | One-cycle result strobe |
| pc_next | output | 32 | Next program counter |
| cnt_out | output | 16 | Updated counter low word |
| set_byte | output | 8 | Set-byte result |
| trap_req | output | 1 | Trap requested |
| trap_vec | output | 8 | Trap vector number |
| invalid | output | 1 | Encoding not accepted |

## Verification
A wrong predicate row shows up as a wrong `set_byte`, a wrong branch target or a wrong trap in the cycle after the offending `start`. The bench therefore sweeps all 64 predicates against all 16 nibbles, including nibbles where NaN is set together with zero or negative. A flawed decrement or wrap test shows in `cnt_out` and `pc_next` on that same single result cycle. An output register that reloads without `start` shows at the first idle cycle, because every output is compared on every clock.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;
  typedef enum logic [1:0] {
    OP_BRANCH = 2'd0,
    OP_DECBR  = 2'd1,
    OP_SETB   = 2'd2,
    OP_TRAP   = 2'd3
  } fpcc_op_e;

  localparam logic [2:0] EXT_HALF = 3'd2;
  localparam logic [2:0] EXT_FULL = 3'd3;
  localparam logic [2:0] EXT_NONE = 3'd4;
endpackage

// File: rtl/fpcc_pred_eval.sv
module fpcc_pred_eval (
  input  logic [5:0] pred,
  input  logic [3:0] cc_nib,
  output logic       truth,
  output logic       pred_bad
);
  logic c_nan, c_zero, c_neg;
  logic unused_bits;

  assign c_nan  = cc_nib[0];
  assign c_zero = cc_nib[2];
  assign c_neg  = cc_nib[3];
  // signaling-variant bit and infinity flag carry no weight in the verdict
  assign unused_bits = pred[4] ^ cc_nib[1];
  assign pred_bad = pred[5];

  always_comb begin
    unique case (pred[3:0])
      4'h0: truth = 1'b0;
      4'h1: truth = c_zero;
      4'h2: truth = !c_neg && !c_zero && !c_nan;
      4'h3: truth = c_zero || (!c_neg && !c_nan);
      4'h4: truth = c_neg && !c_nan && !c_zero;
      4'h5: truth = (c_neg && !c_nan) || c_zero;
      4'h6: truth = !c_nan && !c_zero;
      4'h7: truth = !c_nan;
      4'h8: truth = c_nan;
      4'h9: truth = c_nan || c_zero;
      4'hA: truth = c_nan || (!c_neg && !c_zero);
      4'hB: truth = c_nan || c_zero || !c_neg;
      4'hC: truth = c_nan || (c_neg && !c_zero);
      4'hD: truth = c_neg || c_zero || c_nan;
      4'hE: truth = !c_zero;
      default: truth = 1'b1;
    endcase
  end
endmodule

// File: rtl/fpcc_loop_ctr.sv
module fpcc_loop_ctr #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_in,
  output logic [CNT_W-1:0] cnt_dec,
  output logic             expired
);
  assign cnt_dec = cnt_in - CNT_W'(1);
  // the count has run past zero once the new value is all ones
  assign expired = &cnt_dec;
endmodule

// File: rtl/fpcc_pc_sel.sv
module fpcc_pc_sel
  import fpcc_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int SHORT_W = 16
) (
  input  fpcc_op_e          op,
  input  logic              truth,
  input  logic              bad,
  input  logic              expired,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [PC_W-1:0]   disp,
  input  logic              disp_long,
  input  logic [2:0]        trap_ext,
  output logic [PC_W-1:0]   pc_nxt
);
  localparam int SHORT_BYTES = SHORT_W / 8;
  localparam int LONG_BYTES  = PC_W / 8;

  logic [PC_W-1:0] disp_short;
  logic [PC_W-1:0] disp_sel;
  logic [PC_W-1:0] pc_short_skip;
  logic [PC_W-1:0] pc_long_skip;
  logic [PC_W-1:0] pc_short_tgt;

  generate
    if (PC_W > SHORT_W) begin : g_sext
      assign disp_short = {{(PC_W-SHORT_W){disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
    end else begin : g_plain
      assign disp_short = disp;
    end
  endgenerate

  assign disp_sel      = disp_long ? disp : disp_short;
  assign pc_short_skip = pc_in + PC_W'(SHORT_BYTES);
  assign pc_long_skip  = pc_in + PC_W'(LONG_BYTES);
  assign pc_short_tgt  = pc_in + disp_short;

  always_comb begin
    pc_nxt = pc_in;
    if (!bad) begin
      unique case (op)
        OP_BRANCH: begin
          if (truth)          pc_nxt = pc_in + disp_sel;
          else if (disp_long) pc_nxt = pc_long_skip;
          else                pc_nxt = pc_short_skip;
        end
        OP_DECBR: begin
          if (truth || expired) pc_nxt = pc_short_skip;
          else                  pc_nxt = pc_short_tgt;
        end
        OP_SETB: pc_nxt = pc_in;
        default: begin
          if (trap_ext == EXT_HALF)      pc_nxt = pc_short_skip;
          else if (trap_ext == EXT_FULL) pc_nxt = pc_long_skip;
          else                           pc_nxt = pc_in;
        end
      endcase
    end
  end
endmodule

// File: rtl/fpcc_branch_unit.sv
module fpcc_branch_unit
  import fpcc_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int CNT_W    = 16,
  parameter int SB_W     = 8,
  parameter int VEC_W    = 8,
  parameter int TRAP_VEC = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op_sel,
  input  logic [5:0]        pred,
  input  logic [3:0]        cc_nib,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [PC_W-1:0]   disp,
  input  logic              disp_long,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [2:0]        trap_ext,
  output logic              done,
  output logic [PC_W-1:0]   pc_next,
  output logic [CNT_W-1:0]  cnt_out,
  output logic [SB_W-1:0]   set_byte,
  output logic              trap_req,
  output logic [VEC_W-1:0]  trap_vec,
  output logic              invalid
);
  localparam int SHORT_W = 16;

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  fpcc_op_e         op;
  logic             truth, pred_bad, ext_ok, bad, expired;
  logic [CNT_W-1:0] cnt_dec;
  logic [PC_W-1:0]  pc_calc;

  assign op     = fpcc_op_e'(op_sel);
  assign ext_ok = (trap_ext == EXT_HALF) || (trap_ext == EXT_FULL) || (trap_ext == EXT_NONE);
  assign bad    = pred_bad || ((op == OP_TRAP) && !ext_ok);

  fpcc_pred_eval u_pred (
    .pred     (pred),
    .cc_nib   (cc_nib),
    .truth    (truth),
    .pred_bad (pred_bad)
  );

  fpcc_loop_ctr #(.CNT_W(CNT_W)) u_loop (
    .cnt_in  (cnt_in),
    .cnt_dec (cnt_dec),
    .expired (expired)
  );

  fpcc_pc_sel #(.PC_W(PC_W), .SHORT_W(SHORT_W)) u_pc (
    .op        (op),
    .truth     (truth),
    .bad       (bad),
    .expired   (expired),
    .pc_in     (pc_in),
    .disp      (disp),
    .disp_long (disp_long),
    .trap_ext  (trap_ext),
    .pc_nxt    (pc_calc)
  );

  // next-state
  logic [CNT_W-1:0] nx_cnt;
  logic [SB_W-1:0]  nx_sb;
  logic             nx_trap;
  logic [VEC_W-1:0] nx_vec;

  always_comb begin
    nx_cnt  = cnt_in;
    nx_sb   = '0;
    nx_trap = 1'b0;
    if (!bad) begin
      if (op == OP_DECBR && !truth) nx_cnt  = cnt_dec;
      if (op == OP_SETB && truth)   nx_sb   = '1;
      if (op == OP_TRAP && truth)   nx_trap = 1'b1;
    end
    nx_vec = nx_trap ? VEC_W'(TRAP_VEC) : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      done     <= 1'b0;
      pc_next  <= '0;
      cnt_out  <= '0;
      set_byte <= '0;
      trap_req <= 1'b0;
      trap_vec <= '0;
      invalid  <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        pc_next  <= pc_calc;
        cnt_out  <= nx_cnt;
        set_byte <= nx_sb;
        trap_req <= nx_trap;
        trap_vec <= nx_vec;
        invalid  <= bad;
      end
    end
  end

  // assertions
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_q)
    !start |=> !done);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_q)
    !start |=> $stable(pc_next) && $stable(cnt_out) && $stable(set_byte));
  assert_decbr_true_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (start && op == OP_DECBR && truth && !bad) |=> cnt_out == $past(cnt_in));
  assert_setbyte_R8: assert property (@(posedge clk) disable iff (!rst_q)
    set_byte == '0 || set_byte == '1);
  assert_trap_vec_R9: assert property (@(posedge clk) disable iff (!rst_q)
    trap_req |-> trap_vec == VEC_W'(TRAP_VEC));
  assert_invalid_quiet_R10: assert property (@(posedge clk) disable iff (!rst_q)
    invalid |-> !trap_req && set_byte == '0);
  assert_cnt_keep_R11: assert property (@(posedge clk) disable iff (!rst_q)
    (start && op != OP_DECBR) |=> cnt_out == $past(cnt_in));
endmodule

// File: tb/fpcc_branch_unit_bench.sv
`timescale 1ns/1ps
module fpcc_branch_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op_sel;
  logic [5:0]  pred;
  logic [3:0]  cc_nib;
  logic [31:0] pc_in, disp;
  logic        disp_long;
  logic [15:0] cnt_in;
  logic [2:0]  trap_ext;
  logic        done, trap_req, invalid;
  logic [31:0] pc_next;
  logic [15:0] cnt_out;
  logic [7:0]  set_byte, trap_vec;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  fpcc_branch_unit u_fpcc_branch_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .pred(pred),
    .cc_nib(cc_nib), .pc_in(pc_in), .disp(disp), .disp_long(disp_long),
    .cnt_in(cnt_in), .trap_ext(trap_ext), .done(done), .pc_next(pc_next),
    .cnt_out(cnt_out), .set_byte(set_byte), .trap_req(trap_req),
    .trap_vec(trap_vec), .invalid(invalid)
  );

  function automatic bit verdict(int p, int c);
    bit n = c[0], z = c[2], m = c[3];
    case (p & 15)
      0:  return 0;
      1:  return z;
      2:  return !m && !z && !n;
      3:  return z || (!m && !n);
      4:  return m && !n && !z;
      5:  return (m && !n) || z;
      6:  return !n && !z;
      7:  return !n;
      8:  return n;
      9:  return n || z;
      10: return n || (!m && !z);
      11: return n || z || !m;
      12: return n || (m && !z);
      13: return m || z || n;
      14: return !z;
      default: return 1;
    endcase
  endfunction

  // expected output state
  bit          e_done, e_tr, e_inv;
  logic [31:0] e_pc;
  logic [15:0] e_cnt;
  logic [7:0]  e_sb, e_vec;
  string       lbl_pc, lbl_cnt, lbl_sb, lbl_tr;

  task automatic chk(string req, string fld, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, fld, act, exp, $time);
    end
  endtask

  initial begin
    e_done = 0; e_tr = 0; e_inv = 0; e_pc = '0; e_cnt = '0; e_sb = '0; e_vec = '0;
    lbl_pc = "R1"; lbl_cnt = "R1"; lbl_sb = "R1"; lbl_tr = "R1";
  end

  // reference model, advanced on every clock, compared shortly after the edge
  always begin
    @(posedge clk);
    cyc++;
    if (!rst_n) begin
      e_done = 0; e_tr = 0; e_inv = 0; e_pc = '0; e_cnt = '0; e_sb = '0; e_vec = '0;
      lbl_pc = "R1"; lbl_cnt = "R1"; lbl_sb = "R1"; lbl_tr = "R1";
    end else begin
      e_done = start;
      if (start) begin
        bit t, inv;
        logic [31:0] sx, dv;
        t   = verdict(int'(pred), int'(cc_nib));
        inv = pred[5] || (op_sel == 3 && !(trap_ext inside {3'd2, 3'd3, 3'd4}));
        sx  = {{16{disp[15]}}, disp[15:0]};
        dv  = disp_long ? disp : sx;
        e_pc = pc_in; e_cnt = cnt_in; e_sb = 8'h00; e_tr = 0; e_vec = 8'h00; e_inv = inv;
        lbl_cnt = "R11"; lbl_sb = "R8"; lbl_tr = "R9";
        lbl_pc  = pred[4] ? "R4" : "R3";
        if (inv) begin
          lbl_pc = "R10"; lbl_cnt = "R10"; lbl_sb = "R10"; lbl_tr = "R10";
        end else begin
          case (op_sel)
            2'd0: begin
              e_pc = t ? pc_in + dv : pc_in + (disp_long ? 32'd4 : 32'd2);
              lbl_pc = "R5";
            end
            2'd1: begin
              if (t) begin
                e_pc = pc_in + 32'd2; lbl_pc = "R6"; lbl_cnt = "R6";
              end else begin
                e_cnt = cnt_in - 16'd1;
                e_pc = (e_cnt == 16'hFFFF) ? pc_in + 32'd2 : pc_in + sx;
                lbl_pc = "R7"; lbl_cnt = "R7";
              end
            end
            2'd2: begin
              e_sb = t ? 8'hFF : 8'h00;
              lbl_sb = pred[4] ? "R4" : "R3";
              lbl_pc = "R8";
            end
            default: begin
              e_pc = pc_in + (trap_ext == 3'd2 ? 32'd2 : trap_ext == 3'd3 ? 32'd4 : 32'd0);
              e_tr = t; e_vec = t ? 8'd7 : 8'd0;
              lbl_pc = "R9";
            end
          endcase
        end
      end
    end
    #2;
    chk("R2", "done", 32'(done), 32'(e_done));
    chk(lbl_pc, "pc_next", pc_next, e_pc);
    chk(lbl_cnt, "cnt_out", 32'(cnt_out), 32'(e_cnt));
    chk(lbl_sb, "set_byte", 32'(set_byte), 32'(e_sb));
    chk(lbl_tr, "trap_req", 32'(trap_req), 32'(e_tr));
    chk(lbl_tr, "trap_vec", 32'(trap_vec), 32'(e_vec));
    chk("R10", "invalid", 32'(invalid), 32'(e_inv));
  end

  task automatic issue(int op, int p, int c, logic [31:0] pc, logic [31:0] d,
                       bit lng, logic [15:0] cnt, int ext);
    @(negedge clk);
    op_sel = 2'(op); pred = 6'(p); cc_nib = 4'(c); pc_in = pc; disp = d;
    disp_long = lng; cnt_in = cnt; trap_ext = 3'(ext); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_sel = '0; pred = '0; cc_nib = '0;
    pc_in = '0; disp = '0; disp_long = 1'b0; cnt_in = '0; trap_ext = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // directed corners: loop counter wrap and boundary (R7), trap sizes (R9), invalid (R10)
    issue(1, 6'h00, 0, 32'h1000, 32'h0000_FFF0, 0, 16'h0000, 0);
    issue(1, 6'h00, 0, 32'h1000, 32'h0000_FFF0, 0, 16'h0001, 0);
    issue(1, 6'h10, 0, 32'h1000, 32'h0000_0040, 0, 16'h8000, 0);
    issue(1, 6'h0F, 0, 32'h1000, 32'h0000_0040, 0, 16'h1234, 0);
    issue(0, 6'h0F, 0, 32'h2000, 32'hFFFF_F000, 1, 16'h0000, 0);
    issue(0, 6'h0F, 0, 32'h2000, 32'h0001_8000, 0, 16'h0000, 0);
    issue(0, 6'h00, 0, 32'h2000, 32'h0000_0000, 0, 16'h0000, 0);
    for (int e = 0; e < 8; e++) issue(3, 6'h0F, 0, 32'h3000, 32'h0, 0, 16'h5555, e);
    issue(2, 6'h2F, 0, 32'h4000, 32'h0, 0, 16'h7777, 2);
    issue(0, 6'h01, 5, 32'h4000, 32'h10, 0, 16'h0, 2);   // NaN with zero set
    issue(0, 6'h0C, 5, 32'h4000, 32'h10, 0, 16'h0, 2);

    // sweep every operation, predicate and condition nibble
    for (int op = 0; op < 4; op++)
      for (int p = 0; p < 64; p++)
        for (int c = 0; c < 16; c++) begin
          logic [15:0] cnt = ((p + c) % 5 == 0) ? 16'h0000 : 16'($urandom);
          issue(op, p, c, $urandom, $urandom, bit'(c & 1), cnt, (p + c) % 8);
        end

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule